// File: doc/BRIEF.md
# Reflected CRC-16-CCITT Byte Engine

This block keeps a running 16-bit cyclic redundancy check over a stream of bytes. A host or a DMA engine writes one byte at a time into an 8-bit input register, and each write folds that byte into a 16-bit accumulator using the generator x^16 + x^12 + x^5 + 1. Bytes are treated least significant bit first. This matches a serial link that sends bit 0 of each byte first. A multi-byte word is therefore written starting with its lowest byte.

The accumulator lives in reflected form. The value read back is the bit-reverse of the remainder that a most-significant-bit-first division over the bit-reversed input would produce. Software may write the result register to seed a new calculation; writing zero gives the plain form. A fold completes in one clock. Its result is visible on the cycle after the write strobe.

Top module: `crc16_refl_engine`

## Requirements
- R1: Each folded byte updates the accumulator so that the read value equals rev16(C), where C is the remainder from feeding rev8(byte) most significant bit first into polynomial 0x1021 starting from rev16(previous read value). rev8 and rev16 reverse the bit order over 8 and 16 bits.
- R2: After the result register is seeded with 0x0000 and the bytes 0x78, 0x56, 0x34, 0x12 are written in that order, resultOut reads 0x08F6.
- R3: A write with inByteWe stores wrData[7:0] into the input register, and it appears on inByteOut on the next cycle. Every value from 0x00 to 0xFF is accepted.
- R4: A write with resultWe loads wrData[15:0] into the accumulator, and resultOut shows it on the next cycle. Later bytes fold from that seed.
- R5: The fold of a byte is visible on resultOut one cycle after its strobe. Writes on consecutive cycles are each folded in order.
- R6: A synchronous reset (rst high at a clock edge) clears both the input register and the accumulator to zero.
- R7: In a cycle with neither strobe high, resultOut and inByteOut keep their values.
- R8: When inByteWe and resultWe are high in the same cycle, the accumulator takes the seed value and no fold takes place. The input register still captures wrData[7:0].

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inByteWe | input | 1 | Write strobe for the input byte register |
| resultWe | input | 1 | Write strobe for the result register (seed) |
| wrData | input | 16 | Write data; bits 7:0 for a byte, all 16 bits for a seed |
| inByteOut | output | 8 | Current content of the input byte register |
| resultOut | output | 16 | Current reflected CRC accumulator |

## Verification
The bench compares every fold against a bit-serial model that works in the unreflected, most-significant-bit-first domain. A design that skips the byte reversal, uses 0x1021 in the wrong direction, or presents the unreversed remainder therefore differs on almost every byte. The known four-byte word and long back-to-back bursts catch a fold that drops or repeats a byte when strobes come on consecutive cycles. Directed cases cover a seed issued together with a byte write, a reset in the middle of a stream, and idle cycles. These catch a fold that wins over the seed, an input register that ignores the byte in that cycle, and state that drifts with no strobe.

// File: rtl/crc16_pkg.sv
package crc16_pkg;

  localparam int CRC_W  = 16;
  localparam int BYTE_W = 8;

  // Normal-form generator x^16 + x^12 + x^5 + 1
  localparam logic [CRC_W-1:0] POLY_NORMAL = 16'h1021;

  // Strobes passed from control to datapath
  typedef struct packed {
    logic clearAll;
    logic loadByte;
    logic foldByte;
    logic seedAcc;
  } crcStrobes_t;

  function automatic logic [CRC_W-1:0] reflectWord(input logic [CRC_W-1:0] val);
    logic [CRC_W-1:0] outVal;
    for (int i = 0; i < CRC_W; i++) begin
      outVal[i] = val[CRC_W-1-i];
    end
    return outVal;
  endfunction

endpackage

// File: rtl/crc16_ctrl.sv
module crc16_ctrl
  import crc16_pkg::*;
(
  input  logic        rst,
  input  logic        inByteWe,
  input  logic        resultWe,
  output crcStrobes_t strobes
);

  always_comb begin
    strobes.clearAll = rst;
    strobes.loadByte = !rst && inByteWe;
    strobes.seedAcc  = !rst && resultWe;
    // A seed write in the same cycle wins over the fold
    strobes.foldByte = !rst && inByteWe && !resultWe;
  end

endmodule

// File: rtl/crc16_datapath.sv
module crc16_datapath
  import crc16_pkg::*;
#(
  parameter int              DW        = BYTE_W,
  parameter int              CW        = CRC_W,
  parameter logic [CW-1:0]   POLY_REFL = 16'h8408
) (
  input  logic          clk,
  input  crcStrobes_t   strobes,
  input  logic [CW-1:0] wrData,
  output logic [DW-1:0] inByteQ,
  output logic [CW-1:0] accQ
);

  localparam int PAD_W = CW - DW;

  logic [DW-1:0] newByte;
  logic [CW-1:0] stage [0:DW];

  assign newByte  = wrData[DW-1:0];
  assign stage[0] = accQ ^ {{PAD_W{1'b0}}, newByte};

  // One right-shift step per input bit, unrolled
  genvar g;
  generate
    for (g = 0; g < DW; g++) begin : gStep
      assign stage[g+1] = stage[g][0] ? ((stage[g] >> 1) ^ POLY_REFL)
                                      : (stage[g] >> 1);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strobes.clearAll) begin
      inByteQ <= '0;
    end else if (strobes.loadByte) begin
      inByteQ <= newByte;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.clearAll) begin
      accQ <= '0;
    end else if (strobes.seedAcc) begin
      accQ <= wrData;
    end else if (strobes.foldByte) begin
      accQ <= stage[DW];
    end
  end

endmodule

// File: rtl/crc16_refl_engine.sv
module crc16_refl_engine
  import crc16_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = POLY_NORMAL
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inByteWe,
  input  logic              resultWe,
  input  logic [CRC_W-1:0]  wrData,
  output logic [BYTE_W-1:0] inByteOut,
  output logic [CRC_W-1:0]  resultOut
);

  localparam logic [CRC_W-1:0] POLY_REFL = reflectWord(POLY);

  crcStrobes_t strobes;

  crc16_ctrl i_ctrl (
    .rst      (rst),
    .inByteWe (inByteWe),
    .resultWe (resultWe),
    .strobes  (strobes)
  );

  crc16_datapath #(
    .DW        (BYTE_W),
    .CW        (CRC_W),
    .POLY_REFL (POLY_REFL)
  ) i_datapath (
    .clk     (clk),
    .strobes (strobes),
    .wrData  (wrData),
    .inByteQ (inByteOut),
    .accQ    (resultOut)
  );

endmodule

// File: rtl/crc16_refl_engine_chk.sv
module crc16_refl_engine_chk (
  input logic        clk,
  input logic        rst,
  input logic        inByteWe,
  input logic        resultWe,
  input logic [15:0] wrData,
  input logic [7:0]  inByteOut,
  input logic [15:0] resultOut
);

  logic rstQ = 1'b0;
  always_ff @(posedge clk) rstQ <= rst;

  // R6: outputs are zero on the edge after a reset edge
  p_reset_clear_r6: assert property (@(posedge clk)
    rstQ |-> (resultOut == 16'h0 && inByteOut == 8'h0));

  // R3: byte written shows up on the input register
  p_byte_capture_r3: assert property (@(posedge clk) disable iff (rst)
    inByteWe |=> inByteOut == $past(wrData[7:0]));

  // R4 and R8: seed write lands regardless of a byte strobe
  p_seed_load_r4: assert property (@(posedge clk) disable iff (rst)
    resultWe |=> resultOut == $past(wrData));

  // R7: no strobe, no change
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!inByteWe && !resultWe) |=> ($stable(resultOut) && $stable(inByteOut)));

  // R3: input register only moves on its own strobe
  p_byte_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !inByteWe |=> $stable(inByteOut));

endmodule

bind crc16_refl_engine crc16_refl_engine_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .inByteWe  (inByteWe),
  .resultWe  (resultWe),
  .wrData    (wrData),
  .inByteOut (inByteOut),
  .resultOut (resultOut)
);

// File: tb/test_crc16_refl_engine.sv
module test_crc16_refl_engine;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inByteWe = 1'b0;
  logic        resultWe = 1'b0;
  logic [15:0] wrData = 16'h0;
  logic [7:0]  inByteOut;
  logic [15:0] resultOut;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  // Reference state kept in normal (unreflected) form
  logic [15:0] refCrc = 16'h0;

  always #5 clk = ~clk;

  crc16_refl_engine i_crc16_refl_engine (
    .clk       (clk),
    .rst       (rst),
    .inByteWe  (inByteWe),
    .resultWe  (resultWe),
    .wrData    (wrData),
    .inByteOut (inByteOut),
    .resultOut (resultOut)
  );

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  function automatic logic [15:0] rev16(input logic [15:0] v);
    logic [15:0] r;
    for (int i = 0; i < 16; i++) r[i] = v[15-i];
    return r;
  endfunction

  // Bit-serial MSB-first division over the reversed byte
  function automatic logic [15:0] serialStep(input logic [15:0] crc, input logic [7:0] b);
    logic [7:0]  rb;
    logic        fb;
    logic [15:0] c;
    rb = rev8(b);
    c  = crc;
    for (int i = 7; i >= 0; i--) begin
      fb = c[15] ^ rb[i];
      c  = {c[14:0], 1'b0};
      if (fb) c = c ^ 16'h1021;
    end
    return c;
  endfunction

  function automatic logic [15:0] expRead();
    return rev16(refCrc);
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
      $finish;
    end
  endtask

  task automatic seed(input logic [15:0] s);
    @(negedge clk);
    resultWe = 1'b1; wrData = s;
    @(negedge clk);
    resultWe = 1'b0;
    refCrc = rev16(s);
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk);
    inByteWe = 1'b1; wrData = {$urandom_range(255, 0), b};
    @(negedge clk);
    inByteWe = 1'b0;
    refCrc = serialStep(refCrc, b);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R6: reset state
    check("R6 reset result", resultOut, 16'h0);
    check("R6 reset input", {8'h0, inByteOut}, 16'h0);

    // R2: known word, LSB byte first
    seed(16'h0000);
    writeByte(8'h78); writeByte(8'h56); writeByte(8'h34); writeByte(8'h12);
    check("R2 vector", resultOut, 16'h08F6);
    check("R1 vector model", resultOut, expRead());
    check("R3 last byte", {8'h0, inByteOut}, 16'h0012);

    // R3: boundary byte values
    writeByte(8'hFF);
    check("R3 byte FF", {8'h0, inByteOut}, 16'h00FF);
    check("R1 after FF", resultOut, expRead());
    writeByte(8'h00);
    check("R3 byte 00", {8'h0, inByteOut}, 16'h0000);
    check("R1 after 00", resultOut, expRead());

    // R4: seed and continue
    seed(16'hFFFF);
    check("R4 seed read", resultOut, 16'hFFFF);
    writeByte(8'hA5);
    check("R4 fold from seed", resultOut, expRead());

    // R7: idle cycles hold
    repeat (5) @(negedge clk);
    check("R7 idle result", resultOut, expRead());
    check("R7 idle input", {8'h0, inByteOut}, 16'h00A5);

    // R8: both strobes together
    @(negedge clk);
    inByteWe = 1'b1; resultWe = 1'b1; wrData = 16'h1C3B;
    @(negedge clk);
    inByteWe = 1'b0; resultWe = 1'b0;
    refCrc = rev16(16'h1C3B);
    check("R8 seed wins", resultOut, 16'h1C3B);
    check("R8 input captured", {8'h0, inByteOut}, 16'h003B);

    // R5: back-to-back burst
    seed(16'h0000);
    @(negedge clk);
    for (int i = 0; i < 32; i++) begin
      logic [7:0] b;
      b = 8'($urandom_range(255, 0));
      inByteWe = 1'b1; wrData = {8'h00, b};
      refCrc = serialStep(refCrc, b);
      @(negedge clk);
      check("R5 burst step", resultOut, expRead());
    end
    inByteWe = 1'b0;

    // R6: reset mid-stream
    writeByte(8'h3C);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    refCrc = 16'h0;
    check("R6 mid reset result", resultOut, 16'h0);
    check("R6 mid reset input", {8'h0, inByteOut}, 16'h0);

    // R1: random streams with random seeds and gaps
    for (int s = 0; s < 40; s++) begin
      seed(16'($urandom_range(65535, 0)));
      for (int k = 0; k < 1 + $urandom_range(15, 0); k++) begin
        writeByte(8'($urandom_range(255, 0)));
        check("R1 random stream", resultOut, expRead());
        if ($urandom_range(3, 0) == 0) begin
          @(negedge clk);
          check("R7 gap hold", resultOut, expRead());
        end
      end
    end

    finish();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog expired actual=%h expected=%h", 16'h0, 16'h1);
      finish();
    end
  end

endmodule